// File: doc/BRIEF.md
# Write Buffer with Read-Miss Priority

This block sits between a cache and main memory and owns the single memory port. Every store from a write-through cache, and every dirty block pushed out by a write-back cache, is queued here rather than sent straight to memory. The queue holds four entries in arrival order, and a full flag stalls the producer when all four are taken. When no read is waiting, the memory port writes back the oldest entry, one entry per completed memory handshake.

Read misses have priority over queued writes. When a read request is accepted, its address is compared with every occupied entry, and also with a write being enqueued in the same cycle. On a match the newest matching data is returned straight from the buffer and memory is not touched. With no match, the read goes to memory ahead of all pending writes. A write handshake that has already started is allowed to finish, but the read never waits for the rest of the queue to drain. A dirty block evicted on a read miss is therefore queued first, read traffic goes out next, and the victim reaches memory afterwards.

The controller is a four-state machine. `ST_IDLE` accepts a read or starts a drain. `ST_RD_MEM` holds a memory read until it is acknowledged. `ST_WR_MEM` holds the head write until it is acknowledged. `ST_RESP` presents read data for one cycle. The transitions are:

- Forward hit (`ST_IDLE`→`ST_RESP`): a read is accepted and matches a buffered write.
- Read miss (`ST_IDLE`→`ST_RD_MEM`): a read is accepted and nothing matches.
- Drain start (`ST_IDLE`→`ST_WR_MEM`): no read is present and the buffer is not empty.
- Read done (`ST_RD_MEM`→`ST_RESP`): the memory read is acknowledged.
- Write done (`ST_WR_MEM`→`ST_IDLE`): the head write is acknowledged and popped.
- Response end (`ST_RESP`→`ST_IDLE`): the read data has been presented for its one cycle.

Top module: `wbuf_rdprio`

## Requirements
- R1: After reset the buffer is empty and idle: `enq_full`=0, `mem_req`=0, `rd_rvalid`=0 and `rd_ready`=1.
- R2: Every accepted enqueue is held in the buffer, and it reaches memory only as a write (`mem_we`=1). Writes leave in arrival order with their address, data and kind (`enq_kind`/`mem_kind`: 0 = store, 1 = evicted dirty block).
- R3: `enq_full` is 1 exactly when four entries are held. An enqueue offered while `enq_full`=1 is dropped and never reaches memory.
- R4: An enqueue accepted in the same cycle as a write handshake completes is kept, and the occupancy is left unchanged.
- R5: A read is accepted when `rd_req`=1 and `rd_ready`=1, and `rd_ready` is 1 only in the idle state. With no address match, a memory read (`mem_req`=1, `mem_we`=0, `mem_addr` = the read address) is presented in the cycle after acceptance, ahead of every buffered write.
- R6: On an address match, `rd_rvalid` is 1 in the cycle after acceptance and carries the data of the newest matching write, and no memory read is issued. A write enqueued in the same cycle counts as the newest.
- R7: For a read served by memory, `rd_rvalid` is 1 for exactly one cycle, in the cycle after `mem_ack`, carrying the `mem_rdata` captured with that acknowledge.
- R8: When a dirty-block enqueue and a missing read arrive in the same idle cycle, memory sees the read first and the evicted block's write afterwards.
- R9: When idle with no read requested and the buffer is not empty, the oldest write is presented in the next cycle. A read that arrives while a write is in flight waits only for that one write, not for the rest of the queue.
- R10: Once `mem_req` is raised, it stays high with an unchanged `mem_addr` and `mem_we` (and unchanged `mem_wdata` for a write) until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Offer a write to the buffer |
| enq_addr | input | AW | Address of the offered write |
| enq_data | input | DW | Data of the offered write |
| enq_kind | input | 1 | 0 = store, 1 = evicted dirty block |
| enq_full | output | 1 | Buffer holds four entries; offers are dropped |
| rd_req | input | 1 | Read-miss request |
| rd_addr | input | AW | Read-miss address |
| rd_ready | output | 1 | A read request is accepted this cycle |
| rd_rvalid | output | 1 | Read data valid (one cycle) |
| rd_rdata | output | DW | Read data, from the buffer or from memory |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_kind | output | 1 | Kind of the write being drained |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory completes the current transaction |
| mem_rdata | input | DW | Memory read data, valid with `mem_ack` |

## Verification
Read acceptance, `enq_full` and every new memory request take effect on the rising edge that samples the inputs. A forwarded read response and a memory request are therefore due in the cycle after acceptance, and a memory-served response is due in the cycle after `mem_ack`. The bench drives inputs and compares all outputs at the falling edge, against a queue-based model that it steps once per clock, so each result is checked exactly in the cycle it is due. The directed scenarios check the specific ordering cases at two nanoseconds after the rising edge. These cases are a read overtaking a queued eviction, a read waiting for only one in-flight write, newest-match forwarding, and a push coinciding with a pop.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    // Controller states of the memory-port arbiter
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_MEM = 2'd1,
        ST_WR_MEM = 2'd2,
        ST_RESP   = 2'd3
    } wb_state_e;

    // Kind tag carried with each buffered write
    typedef enum logic {
        KIND_STORE = 1'b0,
        KIND_EVICT = 1'b1
    } wb_kind_e;

endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [AW-1:0]               push_addr,
    input  logic [DW-1:0]               push_data,
    input  logic                        push_kind,
    input  logic                        pop,
    output logic [CW-1:0]               count,
    output logic                        full,
    output logic                        empty,
    output logic                        head_kind,
    output logic [DEPTH-1:0]            ord_vld,
    output logic [DEPTH-1:0][AW-1:0]    ord_addr,
    output logic [DEPTH-1:0][DW-1:0]    ord_data
);

    logic [AW-1:0] st_addr [DEPTH];
    logic [DW-1:0] st_data [DEPTH];
    logic          st_kind [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Entry storage: data is not reset, only the pointers are
    always_ff @(posedge clk) begin
        if (push) begin
            st_addr[wr_ptr] <= push_addr;
            st_data[wr_ptr] <= push_data;
            st_kind[wr_ptr] <= push_kind;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_inc(wr_ptr);
            if (pop)  rd_ptr <= ptr_inc(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    // Present the entries oldest-first: position k is the k-th oldest
    for (genvar k = 0; k < DEPTH; k++) begin : g_ord
        logic [PW:0]   sum;
        logic [PW-1:0] slot;
        assign sum  = {1'b0, rd_ptr} + (PW+1)'(k);
        assign slot = (sum >= (PW+1)'(DEPTH)) ? PW'(sum - (PW+1)'(DEPTH)) : sum[PW-1:0];
        assign ord_vld[k]  = (CW'(k) < count);
        assign ord_addr[k] = st_addr[slot];
        assign ord_data[k] = st_data[slot];
    end

    assign head_kind = st_kind[rd_ptr];

endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic [DEPTH-1:0]            ord_vld,
    input  logic [DEPTH-1:0][AW-1:0]    ord_addr,
    input  logic [DEPTH-1:0][DW-1:0]    ord_data,
    input  logic                        byp_vld,
    input  logic [AW-1:0]               byp_addr,
    input  logic [DW-1:0]               byp_data,
    input  logic [AW-1:0]               look_addr,
    output logic                        hit,
    output logic [DW-1:0]               hit_data
);

    // Walk from oldest to newest so the last match found is the newest;
    // a write entering this very cycle is newer than all stored entries.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (ord_vld[k] && (ord_addr[k] == look_addr)) begin
                hit      = 1'b1;
                hit_data = ord_data[k];
            end
        end
        if (byp_vld && (byp_addr == look_addr)) begin
            hit      = 1'b1;
            hit_data = byp_data;
        end
    end

endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
    import wbuf_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_req,
    input  logic [AW-1:0]   rd_addr,
    input  logic            hit,
    input  logic [DW-1:0]   hit_data,
    input  logic            buf_empty,
    input  logic            mem_ack,
    input  logic [DW-1:0]   mem_rdata,
    output wb_state_e       state,
    output logic [AW-1:0]   pend_addr,
    output logic            rd_ready,
    output logic            rd_rvalid,
    output logic [DW-1:0]   rd_rdata,
    output logic            pop,
    output logic            mem_req,
    output logic            mem_we
);

    wb_state_e     state_nxt;
    logic [DW-1:0] rdata_q;
    logic          rd_take;

    assign rd_take = (state == ST_IDLE) && rd_req;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Next state: a read always outranks a drain start
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (rd_req)          state_nxt = hit ? ST_RESP : ST_RD_MEM;
                else if (!buf_empty) state_nxt = ST_WR_MEM;
            end
            ST_RD_MEM: if (mem_ack) state_nxt = ST_RESP;
            ST_WR_MEM: if (mem_ack) state_nxt = ST_IDLE;
            ST_RESP:                state_nxt = ST_IDLE;
            default:                state_nxt = ST_IDLE;
        endcase
    end

    // Read address and read data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_addr <= '0;
            rdata_q   <= '0;
        end else begin
            if (rd_take) pend_addr <= rd_addr;
            if (rd_take && hit)                      rdata_q <= hit_data;
            else if ((state == ST_RD_MEM) && mem_ack) rdata_q <= mem_rdata;
        end
    end

    // Outputs decoded from the state only
    always_comb begin
        rd_ready  = 1'b0;
        rd_rvalid = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        pop       = 1'b0;
        unique case (state)
            ST_IDLE:   rd_ready = 1'b1;
            ST_RD_MEM: mem_req  = 1'b1;
            ST_WR_MEM: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                pop     = mem_ack;
            end
            ST_RESP:   rd_rvalid = 1'b1;
            default:   rd_ready  = 1'b0;
        endcase
    end

    assign rd_rdata = rdata_q;

endmodule

// File: rtl/wbuf_rdprio.sv
module wbuf_rdprio
    import wbuf_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enq_valid,
    input  logic [AW-1:0]   enq_addr,
    input  logic [DW-1:0]   enq_data,
    input  logic            enq_kind,
    output logic            enq_full,
    input  logic            rd_req,
    input  logic [AW-1:0]   rd_addr,
    output logic            rd_ready,
    output logic            rd_rvalid,
    output logic [DW-1:0]   rd_rdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic            mem_kind,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_ack,
    input  logic [DW-1:0]   mem_rdata
);

    localparam int CW = $clog2(DEPTH + 1);

    logic                      push;
    logic                      pop;
    logic [CW-1:0]             buf_count;
    logic                      buf_empty;
    logic                      head_kind;
    logic [DEPTH-1:0]          ord_vld;
    logic [DEPTH-1:0][AW-1:0]  ord_addr;
    logic [DEPTH-1:0][DW-1:0]  ord_data;
    logic                      hit;
    logic [DW-1:0]             hit_data;
    wb_state_e                 ctrl_state;
    logic [AW-1:0]             pend_addr;

    assign push = enq_valid && !enq_full;

    wbuf_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (enq_addr),
        .push_data (enq_data),
        .push_kind (enq_kind),
        .pop       (pop),
        .count     (buf_count),
        .full      (enq_full),
        .empty     (buf_empty),
        .head_kind (head_kind),
        .ord_vld   (ord_vld),
        .ord_addr  (ord_addr),
        .ord_data  (ord_data)
    );

    wbuf_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
        .ord_vld   (ord_vld),
        .ord_addr  (ord_addr),
        .ord_data  (ord_data),
        .byp_vld   (push),
        .byp_addr  (enq_addr),
        .byp_data  (enq_data),
        .look_addr (rd_addr),
        .hit       (hit),
        .hit_data  (hit_data)
    );

    wbuf_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .hit       (hit),
        .hit_data  (hit_data),
        .buf_empty (buf_empty),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .state     (ctrl_state),
        .pend_addr (pend_addr),
        .rd_ready  (rd_ready),
        .rd_rvalid (rd_rvalid),
        .rd_rdata  (rd_rdata),
        .pop       (pop),
        .mem_req   (mem_req),
        .mem_we    (mem_we)
    );

    // Memory port: a read uses the captured address, a write the oldest entry
    assign mem_addr  = (ctrl_state == ST_RD_MEM) ? pend_addr : ord_addr[0];
    assign mem_wdata = ord_data[0];
    assign mem_kind  = head_kind;

endmodule

// File: rtl/wbuf_rdprio_chk.sv
module wbuf_rdprio_chk #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enq_valid,
    input  logic            enq_full,
    input  logic            rd_req,
    input  logic            rd_ready,
    input  logic            rd_rvalid,
    input  logic            mem_req,
    input  logic            mem_we,
    input  logic            mem_ack,
    input  logic [AW-1:0]   mem_addr,
    input  logic [DW-1:0]   mem_wdata,
    input  logic [CW-1:0]   buf_count
);

    logic wr_done;
    assign wr_done = mem_req && mem_we && mem_ack;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        buf_count <= CW'(DEPTH)); // R3

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        enq_full && !wr_done |=> enq_full); // R3

    AST_SIMUL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        enq_valid && !enq_full && wr_done |=> $stable(buf_count)); // R4

    AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_ready |=> !(mem_req && mem_we)); // R5

    AST_RESP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rvalid |=> !rd_rvalid && rd_ready); // R7

    AST_DRAIN_START: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready && !rd_req && (buf_count != '0) |=> mem_req && mem_we); // R9

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr)); // R10

    AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && !mem_ack |=> $stable(mem_wdata)); // R10

endmodule

bind wbuf_rdprio wbuf_rdprio_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enq_valid (enq_valid),
    .enq_full  (enq_full),
    .rd_req    (rd_req),
    .rd_ready  (rd_ready),
    .rd_rvalid (rd_rvalid),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .buf_count (buf_count)
);

// File: tb/wbuf_rdprio_bench.sv
module wbuf_rdprio_bench;

    localparam int AW    = 16;
    localparam int DW    = 32;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst_n;
    logic            enq_valid, enq_kind, enq_full;
    logic [AW-1:0]   enq_addr, rd_addr, mem_addr;
    logic [DW-1:0]   enq_data, rd_rdata, mem_wdata, mem_rdata;
    logic            rd_req, rd_ready, rd_rvalid;
    logic            mem_req, mem_we, mem_kind, mem_ack;

    wbuf_rdprio #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_wbuf_rdprio (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_addr(enq_addr), .enq_data(enq_data),
        .enq_kind(enq_kind), .enq_full(enq_full),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_kind(mem_kind),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic          k;
    } ent_t;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference model: 0 idle, 1 memory read, 2 memory write, 3 response
    ent_t          q[$];
    int            md;
    logic [AW-1:0] m_raddr;
    logic [DW-1:0] m_rdata;

    // Stimulus for the next cycle
    logic          s_ev, s_ek, s_rr;
    logic [AW-1:0] s_ea, s_ra;
    logic [DW-1:0] s_ed;
    int            ackmode;   // 0 random latency, 1 never, 2 at once
    int            lat, waitc;
    int unsigned   rng = 32'h1234_5678;

    logic          last_wait, last_we;
    logic [AW-1:0] last_addr;
    logic [AW-1:0] obs[$];    // addresses of completed memory writes

    function int unsigned nextr();
        rng ^= rng << 13;
        rng ^= rng >> 17;
        rng ^= rng << 5;
        return rng;
    endfunction

    function automatic logic [DW-1:0] memfn(input logic [AW-1:0] a);
        return {a ^ 16'h5a5a, a};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_stim();
        s_ev = 1'b0; s_rr = 1'b0;
    endtask

    task automatic peek();
        @(posedge clk);
        #2;
    endtask

    // One clock: compare at the falling edge, step the model, drive inputs
    task automatic cycle();
        logic          ack, hit, push, pop, busy;
        logic [DW-1:0] hd;
        @(negedge clk);
        busy = (md == 1) || (md == 2);
        chk(rd_ready === (md == 0), "R5", "rd_ready", 64'(rd_ready), 64'(md == 0));
        chk(mem_req === busy, "R9", "mem_req", 64'(mem_req), 64'(busy));
        if (busy) begin
            chk(mem_we === (md == 2), "R5", "mem_we", 64'(mem_we), 64'(md == 2));
            if (md == 1) chk(mem_addr === m_raddr, "R5", "read address", 64'(mem_addr), 64'(m_raddr));
            else begin
                chk(mem_addr === q[0].a, "R2", "write address", 64'(mem_addr), 64'(q[0].a));
                chk(mem_wdata === q[0].d, "R2", "write data", 64'(mem_wdata), 64'(q[0].d));
                chk(mem_kind === q[0].k, "R2", "write kind", 64'(mem_kind), 64'(q[0].k));
            end
        end
        chk(enq_full === (q.size() == DEPTH), "R3", "enq_full", 64'(enq_full), 64'(q.size() == DEPTH));
        chk(rd_rvalid === (md == 3), "R6", "rd_rvalid", 64'(rd_rvalid), 64'(md == 3));
        if (md == 3) chk(rd_rdata === m_rdata, "R7", "read data", 64'(rd_rdata), 64'(m_rdata));
        if (last_wait)
            chk(mem_req === 1'b1 && mem_addr === last_addr && mem_we === last_we, "R10",
                "request held", 64'({mem_req, mem_addr}), 64'({1'b1, last_addr}));

        ack = 1'b0;
        if (busy) begin
            if (ackmode == 2) ack = 1'b1;
            else if (ackmode == 0) begin
                if (waitc >= lat) begin
                    ack = 1'b1; waitc = 0; lat = int'(nextr() % 3);
                end else waitc++;
            end
        end
        last_wait = busy && !ack;
        last_addr = mem_addr;
        last_we   = mem_we;
        if (ack && mem_we) obs.push_back(mem_addr);

        push = s_ev && (q.size() < DEPTH);
        pop  = (md == 2) && ack;
        case (md)
            0: begin
                if (s_rr) begin
                    hit = 1'b0; hd = '0;
                    foreach (q[i]) if (q[i].a == s_ra) begin hit = 1'b1; hd = q[i].d; end
                    if (push && s_ea == s_ra) begin hit = 1'b1; hd = s_ed; end
                    if (hit) begin md = 3; m_rdata = hd; end
                    else     begin md = 1; m_raddr = s_ra; end
                end else if (q.size() > 0) md = 2;
            end
            1: if (ack) begin md = 3; m_rdata = memfn(m_raddr); end
            2: if (ack) md = 0;
            default: md = 0;
        endcase
        if (pop)  void'(q.pop_front());
        if (push) q.push_back('{a: s_ea, d: s_ed, k: s_ek});

        enq_valid = s_ev; enq_addr = s_ea; enq_data = s_ed; enq_kind = s_ek;
        rd_req    = s_rr; rd_addr  = s_ra;
        mem_ack   = ack;
        mem_rdata = ack ? memfn(mem_addr) : '0;
    endtask

    task automatic push_one(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic k);
        idle_stim();
        s_ev = 1'b1; s_ea = a; s_ed = d; s_ek = k;
        cycle();
        idle_stim();
    endtask

    task automatic drain();
        ackmode = 0;
        idle_stim();
        repeat (40) cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit found;
        rst_n = 1'b0;
        enq_valid = 0; enq_addr = '0; enq_data = '0; enq_kind = 0;
        rd_req = 0; rd_addr = '0; mem_ack = 0; mem_rdata = '0;
        s_ea = '0; s_ed = '0; s_ek = 0; s_ra = '0; idle_stim();
        md = 0; m_raddr = '0; m_rdata = '0; ackmode = 0; lat = 1; waitc = 0;
        last_wait = 0; last_we = 0; last_addr = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(enq_full === 1'b0 && mem_req === 1'b0 && rd_rvalid === 1'b0 && rd_ready === 1'b1,
            "R1", "reset outputs", 64'({enq_full, mem_req, rd_rvalid, rd_ready}), 64'(4'b0001));
        rst_n = 1'b1;

        // R8: eviction and missing read in the same cycle
        idle_stim();
        s_ev = 1; s_ea = 16'h0200; s_ed = 32'hE0E0_0001; s_ek = 1;
        s_rr = 1; s_ra = 16'h0300;
        cycle();
        idle_stim();
        peek();
        chk(mem_req && !mem_we && mem_addr == 16'h0300, "R8", "read goes first",
            64'({mem_req, mem_we, mem_addr}), 64'({2'b10, 16'h0300}));
        found = 0;
        for (int i = 0; i < 12 && !found; i++) begin
            cycle();
            peek();
            if (mem_req && mem_we) begin
                found = 1;
                chk(mem_addr == 16'h0200 && mem_kind == 1'b1, "R8", "victim written after read",
                    64'({mem_kind, mem_addr}), 64'({1'b1, 16'h0200}));
            end
        end
        chk(found, "R8", "victim write seen", 64'(found), 64'(1));
        drain();

        // R3: fill beyond capacity with memory stalled
        obs.delete();
        ackmode = 1;
        for (int i = 0; i < 5; i++) push_one(16'h1000 + 16'(i * 4), 32'hF000 + 32'(i), 1'b0);
        cycle();
        peek();
        chk(enq_full === 1'b1, "R3", "full after four", 64'(enq_full), 64'(1));
        drain();
        chk(obs.size() == 4, "R3", "writes drained", 64'(obs.size()), 64'(4));
        for (int i = 0; i < 4 && i < obs.size(); i++)
            chk(obs[i] == 16'h1000 + 16'(i * 4), "R2", "drain order", 64'(obs[i]), 64'(16'h1000 + 16'(i * 4)));

        // R4: push while a write completes
        obs.delete();
        ackmode = 1;
        for (int i = 0; i < 3; i++) push_one(16'h2000 + 16'(i * 4), 32'hA000 + 32'(i), 1'b0);
        idle_stim(); cycle();
        s_ev = 1; s_ea = 16'h200c; s_ed = 32'hA003; s_ek = 0; ackmode = 2;
        cycle();
        idle_stim(); ackmode = 1;
        cycle();
        peek();
        chk(enq_full === 1'b0, "R4", "occupancy kept at three", 64'(enq_full), 64'(0));
        push_one(16'h2010, 32'hA004, 1'b1);
        peek();
        chk(enq_full === 1'b1, "R4", "fourth slot then full", 64'(enq_full), 64'(1));
        drain();
        chk(obs.size() == 5, "R4", "all five written", 64'(obs.size()), 64'(5));
        for (int i = 0; i < 5 && i < obs.size(); i++)
            chk(obs[i] == 16'h2000 + 16'(i * 4), "R4", "write order", 64'(obs[i]), 64'(16'h2000 + 16'(i * 4)));

        // R9: a read waits for one in-flight write only
        ackmode = 1;
        for (int i = 0; i < 3; i++) push_one(16'h3000 + 16'(i * 4), 32'hB000 + 32'(i), 1'b0);
        idle_stim(); cycle();
        s_rr = 1; s_ra = 16'h3100; ackmode = 2;
        cycle();
        ackmode = 1;
        cycle();
        idle_stim();
        peek();
        chk(mem_req && !mem_we && mem_addr == 16'h3100, "R9", "read after one write",
            64'({mem_req, mem_we, mem_addr}), 64'({2'b10, 16'h3100}));
        drain();

        // R6: newest matching entry is forwarded
        ackmode = 1;
        push_one(16'h4000, 32'hC000_0001, 1'b0);
        push_one(16'h4400, 32'hC000_0002, 1'b0);
        push_one(16'h4400, 32'hC000_0003, 1'b1);
        idle_stim(); cycle();
        s_rr = 1; s_ra = 16'h4400; ackmode = 2;
        cycle();
        ackmode = 1;
        cycle();
        idle_stim();
        peek();
        chk(rd_rvalid && rd_rdata == 32'hC000_0003 && !mem_req, "R6", "newest forwarded",
            64'({mem_req, rd_rvalid, rd_rdata}), 64'({2'b01, 32'hC000_0003}));
        drain();

        // R6: write entering in the same cycle is forwarded
        s_ev = 1; s_ea = 16'h4800; s_ed = 32'hC000_0004; s_ek = 0;
        s_rr = 1; s_ra = 16'h4800;
        cycle();
        idle_stim();
        peek();
        chk(rd_rvalid && rd_rdata == 32'hC000_0004, "R6", "same-cycle forward",
            64'({rd_rvalid, rd_rdata}), 64'({1'b1, 32'hC000_0004}));
        drain();

        // R7: read served by memory
        s_rr = 1; s_ra = 16'h5000;
        cycle();
        idle_stim();
        found = 0;
        for (int i = 0; i < 10 && !found; i++) begin
            cycle();
            peek();
            if (rd_rvalid) begin
                found = 1;
                chk(rd_rdata == memfn(16'h5000), "R7", "memory read data",
                    64'(rd_rdata), 64'(memfn(16'h5000)));
            end
        end
        chk(found, "R7", "memory response seen", 64'(found), 64'(1));
        drain();

        // Mixed traffic compared against the model every cycle
        for (int n = 0; n < 4000; n++) begin
            int unsigned r;
            r = nextr();
            s_ev = (r % 3) == 0;
            s_ea = 16'h6000 + 16'(((r >> 4) % 6) * 4);
            s_ed = 32'(n);
            s_ek = r[8];
            s_rr = ((r >> 12) % 5) == 0;
            s_ra = 16'h6000 + 16'(((r >> 16) % 8) * 4);
            cycle();
        end
        drain();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule